// File: doc/BRIEF.md
# Shared Virtual-Channel Buffer Block Allocator

This unit sits inside one router and owns a pool of virtual-channel buffer blocks. The pool is not split up by port. When a transaction has been given a path, the routing stage raises an allocate request carrying the chosen output port and a transaction tag. The allocator then binds the lowest-numbered free block to that port and answers with a grant and the block number.

When the transaction closes its channel, a release request carrying the same tag returns the block to the pool. Any port can use that block on its next allocation. If no block is free, the allocate request is refused with a failure pulse, which a system monitor can collect so the requester waits or escalates.

The block table is the router's current buffer configuration. It is visible at all times as a valid vector and a port field per block, and a per-port count of bound blocks is derived from it.

Top module: `vcb_alloc`

## Requirements
- R1: During and after reset every block is free, every port count is zero, and `grant_vld`, `alloc_fail` and `rel_err` are low.
- R2: An allocate request with a free block available is answered on the next clock edge, well inside a 4-cycle route window. `grant_vld` pulses for one cycle with `grant_blk` equal to the lowest-indexed free block. That block's valid bit is set and its 3-bit port field (bits 3b+2..3b of `blk_port`) holds the requested port.
- R3: An allocate request while every block is bound pulses `alloc_fail` on the next edge and leaves the block table unchanged. `grant_vld` and `alloc_fail` are never high together.
- R4: A release whose tag matches a bound block frees the lowest-indexed such block on the next edge and clears its port field to 0. The freed block may later be granted to any port.
- R5: A release whose tag matches no bound block pulses `rel_err` on the next edge and changes no block.
- R6: When an allocate and a release arrive in the same cycle, the release is applied first. A block freed by that release can be granted to the simultaneous allocation, even from a full pool.
- R7: `port_cnt` holds, in field p (bits 4p+3..4p), the number of bound blocks whose port field equals p, for every port p below the port count.
- R8: An allocate request naming a port number equal to or above the port count is refused with `alloc_fail` and changes no block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocate request strobe |
| alloc_port | input | 3 | Output port the new transaction was routed to |
| alloc_id | input | ID_W (4) | Transaction tag stored with the block |
| rel_req | input | 1 | Release request strobe |
| rel_id | input | ID_W (4) | Tag of the transaction that ended |
| grant_vld | output | 1 | One-cycle grant pulse |
| grant_blk | output | clog2(NUM_BLK) (3) | Index of the granted block |
| alloc_fail | output | 1 | One-cycle refusal pulse (pool full or bad port) |
| rel_err | output | 1 | One-cycle pulse for a release with an unknown tag |
| blk_valid | output | NUM_BLK (8) | Bound flag per block |
| blk_port | output | 3*NUM_BLK (24) | Port field per block, block b at bits 3b+2..3b |
| port_cnt | output | 4*NUM_PORT (20) | Bound-block count per port, port p at bits 4p+3..4p |

## Verification
Allocation and release can land in the same cycle, and their order decides whether a full pool can serve a request. The bench provokes this by filling all blocks and then pairing a release of a bound tag with an allocation to a different port. The grant must name exactly the block that was freed. A release with an unknown tag is also paired with an allocation on a full pool, which must produce both `rel_err` and `alloc_fail`. A behavioural model applies release before allocate every cycle and compares every output on every clock during a long random mix of both requests.

// File: rtl/vcb_pkg.sv
package vcb_pkg;
  localparam int PORT_W = 3;

  // a port number is usable only below the configured port count
  function automatic logic port_ok(input logic [PORT_W-1:0] p, input int nports);
    return int'(p) < nports;
  endfunction
endpackage

// File: rtl/vcb_first_set.sv
module vcb_first_set #(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vcb_port_count.sv
module vcb_port_count #(
  parameter int NB = 8,
  parameter int NP = 5,
  parameter int PW = 3,
  parameter int CW = 4
) (
  input  logic [NB-1:0]    valid,
  input  logic [NB*PW-1:0] ports,
  output logic [NP*CW-1:0] counts
);
  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [CW-1:0] sum;
    always_comb begin
      sum = '0;
      for (int b = 0; b < NB; b++)
        if (valid[b] && ports[b*PW +: PW] == PW'(p)) sum = sum + 1'b1;
    end
    assign counts[p*CW +: CW] = sum;
  end
endmodule

// File: rtl/vcb_alloc.sv
module vcb_alloc
  import vcb_pkg::*;
#(
  parameter int NUM_BLK  = 8,
  parameter int NUM_PORT = 5,
  parameter int ID_W     = 4,
  localparam int BW = $clog2(NUM_BLK),
  localparam int CW = $clog2(NUM_BLK + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_req,
  input  logic [PORT_W-1:0]        alloc_port,
  input  logic [ID_W-1:0]          alloc_id,
  input  logic                     rel_req,
  input  logic [ID_W-1:0]          rel_id,
  output logic                     grant_vld,
  output logic [BW-1:0]            grant_blk,
  output logic                     alloc_fail,
  output logic                     rel_err,
  output logic [NUM_BLK-1:0]       blk_valid,
  output logic [NUM_BLK*PORT_W-1:0] blk_port,
  output logic [NUM_PORT*CW-1:0]   port_cnt
);

  function automatic logic [NUM_BLK-1:0] onehot(input logic [BW-1:0] i);
    return NUM_BLK'(1) << i;
  endfunction

  logic [NUM_BLK-1:0] v_q;
  logic [PORT_W-1:0]  port_q [NUM_BLK];
  logic [ID_W-1:0]    id_q   [NUM_BLK];

  // named internal events
  logic [NUM_BLK-1:0] tag_hit;
  logic               rel_hit, rel_fire;
  logic [BW-1:0]      rel_idx;
  logic [NUM_BLK-1:0] v_after_rel;
  logic               free_any, alloc_ok;
  logic [BW-1:0]      free_idx;

  always_comb
    for (int b = 0; b < NUM_BLK; b++) tag_hit[b] = v_q[b] && (id_q[b] == rel_id);

  vcb_first_set #(.W(NUM_BLK)) u_rel_pick (.vec(tag_hit), .found(rel_hit), .idx(rel_idx));

  assign rel_fire    = rel_req && rel_hit;
  assign v_after_rel = v_q & ~(rel_fire ? onehot(rel_idx) : '0);

  vcb_first_set #(.W(NUM_BLK)) u_free_pick (.vec(~v_after_rel), .found(free_any), .idx(free_idx));

  assign alloc_ok = alloc_req && free_any && port_ok(alloc_port, NUM_PORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q        <= '0;
      grant_vld  <= 1'b0;
      grant_blk  <= '0;
      alloc_fail <= 1'b0;
      rel_err    <= 1'b0;
      for (int b = 0; b < NUM_BLK; b++) begin
        port_q[b] <= '0;
        id_q[b]   <= '0;
      end
    end else begin
      v_q <= v_after_rel | (alloc_ok ? onehot(free_idx) : '0);
      if (rel_fire) port_q[rel_idx] <= '0;
      if (alloc_ok) begin
        port_q[free_idx] <= alloc_port;
        id_q[free_idx]   <= alloc_id;
      end
      grant_vld  <= alloc_ok;
      grant_blk  <= alloc_ok ? free_idx : '0;
      alloc_fail <= alloc_req && !alloc_ok;
      rel_err    <= rel_req && !rel_hit;
    end
  end

  assign blk_valid = v_q;
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_flat
    assign blk_port[b*PORT_W +: PORT_W] = port_q[b];
  end

  vcb_port_count #(.NB(NUM_BLK), .NP(NUM_PORT), .PW(PORT_W), .CW(CW)) u_cnt (
    .valid(v_q), .ports(blk_port), .counts(port_cnt)
  );

  // assertions
  p_grant_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_vld && alloc_fail));

  p_grant_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && grant_vld |-> v_q[grant_blk] && port_q[grant_blk] == $past(alloc_port));

  p_fail_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && alloc_fail |-> (&v_q) || !port_ok($past(alloc_port), NUM_PORT));

  p_relerr_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && rel_err && !$past(alloc_ok) |-> v_q == $past(v_q));

  p_release_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_fire && !(alloc_ok && free_idx == rel_idx) |=> !v_q[$past(rel_idx)]);

  p_reuse_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rel_fire && alloc_ok && (&v_q) |=> grant_vld && grant_blk == $past(rel_idx));
endmodule

// File: tb/vcb_alloc_test.sv
module vcb_alloc_test;
  localparam int NB = 8, NP = 5, IDW = 4, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_req = 1'b0, rel_req = 1'b0;
  logic [2:0] alloc_port = '0;
  logic [IDW-1:0] alloc_id = '0, rel_id = '0;
  logic grant_vld, alloc_fail, rel_err;
  logic [2:0] grant_blk;
  logic [NB-1:0] blk_valid;
  logic [NB*3-1:0] blk_port;
  logic [NP*CW-1:0] port_cnt;

  always #10 clk = ~clk;

  vcb_alloc uut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_port(alloc_port),
    .alloc_id(alloc_id), .rel_req(rel_req), .rel_id(rel_id), .grant_vld(grant_vld),
    .grant_blk(grant_blk), .alloc_fail(alloc_fail), .rel_err(rel_err),
    .blk_valid(blk_valid), .blk_port(blk_port), .port_cnt(port_cnt)
  );

  int checks = 0, errors = 0;
  bit m_v [NB];
  int m_p [NB];
  int m_id[NB];
  bit e_gv, e_fail, e_rerr;
  int e_blk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk(req, "grant_vld", grant_vld, e_gv);
    if (e_gv) chk(req, "grant_blk", grant_blk, e_blk);
    chk(req, "alloc_fail", alloc_fail, e_fail);
    chk(req, "rel_err", rel_err, e_rerr);
    for (int b = 0; b < NB; b++) begin
      chk(req, $sformatf("valid[%0d]", b), blk_valid[b], m_v[b]);
      chk(req, $sformatf("port[%0d]", b), blk_port[b*3 +: 3], m_p[b]);
    end
    for (int p = 0; p < NP; p++) begin
      int n = 0;
      for (int b = 0; b < NB; b++) if (m_v[b] && m_p[b] == p) n++;
      chk("R7", $sformatf("count[%0d]", p), port_cnt[p*CW +: CW], n);
    end
  endtask

  // one request cycle: drive at negedge, model release-then-allocate, compare after the edge
  task automatic step(string req, bit a, int port, int aid, bit r, int rid);
    alloc_req = a; alloc_port = 3'(port); alloc_id = IDW'(aid);
    rel_req = r; rel_id = IDW'(rid);
    e_gv = 0; e_fail = 0; e_rerr = 0; e_blk = 0;
    if (r) begin
      int hit = -1;
      for (int b = NB - 1; b >= 0; b--) if (m_v[b] && m_id[b] == rid) hit = b;
      if (hit < 0) e_rerr = 1;
      else begin m_v[hit] = 0; m_p[hit] = 0; end
    end
    if (a) begin
      int fr = -1;
      for (int b = NB - 1; b >= 0; b--) if (!m_v[b]) fr = b;
      if (port >= NP || fr < 0) e_fail = 1;
      else begin
        e_gv = 1; e_blk = fr;
        m_v[fr] = 1; m_p[fr] = port; m_id[fr] = aid;
      end
    end
    @(posedge clk);
    @(negedge clk);
    alloc_req = 0; rel_req = 0;
    compare(req);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_v[b] = 0; m_p[b] = 0; m_id[b] = 0; end
    e_gv = 0; e_fail = 0; e_rerr = 0; e_blk = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: fill the pool across ports
    for (int i = 0; i < NB; i++) step("R2", 1, i % NP, i, 0, 0);
    // R3: full pool refuses
    step("R3", 1, 2, 9, 0, 0);
    // R4: free block 3 and rebind it to another port
    step("R4", 0, 0, 0, 1, 3);
    step("R4", 1, 4, 11, 0, 0);
    // R5: unknown tag
    step("R5", 0, 0, 0, 1, 15);
    // R6: full pool, release and allocate together
    step("R6", 1, 1, 12, 1, 5);
    step("R6", 1, 0, 13, 1, 14);
    // R8: port out of range with free blocks
    step("R4", 0, 0, 0, 1, 0);
    step("R8", 1, 6, 7, 0, 0);
    step("R8", 1, 5, 7, 0, 0);
    // random mix of both requests
    for (int i = 0; i < 400; i++)
      step("R6", $urandom_range(0, 2) != 0, $urandom_range(0, 5), $urandom_range(0, 15),
           $urandom_range(0, 1) != 0, $urandom_range(0, 15));
    // R1 again: reset mid-run clears the table
    rst_n = 1'b0;
    for (int b = 0; b < NB; b++) begin m_v[b] = 0; m_p[b] = 0; end
    e_gv = 0; e_fail = 0; e_rerr = 0;
    @(posedge clk); @(negedge clk);
    compare("R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule